// File: doc/BRIEF.md
# Interline CCD drive timing generator

This block produces every digital drive phase that an interline-transfer CCD needs to read out interlaced fields. From a single timing clock it derives a pixel-period tick, a pixel position within the line and a line position within the field. From those it decodes the following outputs:
- a four-phase vertical transfer pattern;
- two overlapping horizontal transfer clocks;
- a reset gate pulse for every pixel period;
- two readout pulses, whose order depends on the field parity;
- substrate drain pulses that implement a variable electronic shutter.

All outputs are logic levels for an external level-shifting driver. Alongside them the block gives a blanking flag and two qualifiers, one for effective pixels and one for optical-black pixels, so that the downstream sampler knows what each pixel period carries.

Each pixel period lasts `PIX_TICKS` clocks, and `PIX_TICKS` must be even and at least 4. A line is laid out as follows:
1. `HBLK` blanking periods.
2. `HDUM` horizontal dummy bits.
3. `HOBF` front optical-black pixels.
4. `HEFF` effective pixels.
5. `HOBR` rear optical-black pixels.

A frame of `FRAME_LINES` lines is split into two fields. The odd field takes the larger half and the even field the smaller. After `VBLK` blanking lines, a field carries its output lines in this order: `VOBF` optical-black lines, `VEFF` effective lines and `VOBR` optical-black lines. An even field inserts one vertical dummy line ahead of these. Every parameter is a count of clocks, pixel periods or lines, so durations given in time are set by choosing counts.

The field parity input `fld_even_i` and the shutter setting `shut_i` are captured only at the first clock of each field. The shutter setting is the number of storage lines before the field end.

Top module: `ccdtg_top`

## Requirements
- R1: While `rst` is high, and in the first output cycle after it, the outputs are: `v_o`=4'b0011, `h1_o`=1, `h2_o`=0, `blk_o`=1, and `rg_o`, `sub_o`, `sg1_o`, `sg3_o`, `pix_ok_o`, `ob_ok_o`, `even_o` all 0. Every output is registered, so the outputs show the timing position one clock after the counters reach it.
- R2: Within a line, pixel periods 0..HBLK-1 are horizontal blanking. `blk_o` is high in horizontal blanking and on every line that is not an output line; it is low everywhere else.
- R3: An odd field lasts ceil(FRAME_LINES/2) lines and an even field lasts floor(FRAME_LINES/2) lines. The first output line is line VBLK in an odd field and line VBLK+1 in an even field, where line VBLK of an even field is the dummy line.
- R4: `pix_ok_o` is high on effective lines during the HEFF effective pixel periods that follow the dummy bits and front OB. `ob_ok_o` is high on output lines during the non-dummy, non-blank pixel periods that are not effective pixels. The two are never high together and never high with `blk_o`.
- R5: Outside horizontal blanking, with tick index k inside a pixel period, `h1_o` is high for k <= PIX_TICKS/2 and `h2_o` is high for k >= PIX_TICKS/2 or k == 0. Both are high at each transition and they are never low together. In horizontal blanking the output is `h1_o`=1, `h2_o`=0.
- R6: `rg_o` is a single-clock pulse at tick 1 of every pixel period outside horizontal blanking, and never in blanking.
- R7: `v_o` (bit 0 = phase 1) rests at 4'b0011. In horizontal blanking of every line except the readout line, it steps through 4'b0110, 4'b1100 and 4'b1001, each state held for VT_W pixel periods from period VT_P0, and then returns to rest. Exactly two adjacent phases are high at all times, and every change moves to a neighbouring state.
- R8: On line RD_LINE there are two readout pulses, each RD_W pixel periods long. The first starts at pixel RD_P0 and the second begins RD_GAP periods after the first ends. In an odd field `sg1_o` is first; in an even field `sg3_o` is first. The two never overlap.
- R9: With captured shutter value s and field length F, `sub_o` is high for SUB_W pixel periods from period SUB_P0 of the horizontal blanking on every line l where RD_LINE < l and l + s < F. A value of s >= F gives no drain pulses.
- R10: `fld_even_i` and `shut_i` are captured only at the first clock of a field; changes at any other time have no effect on that field. `even_o` shows the captured parity for the whole field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, PIX_TICKS per pixel period |
| rst | input | 1 | Synchronous reset, active high |
| fld_even_i | input | 1 | Parity for the next field, 1 = even |
| shut_i | input | SHUT_W | Storage length in lines before field end |
| v_o | output | 4 | Vertical transfer phases, bit 0 = phase 1 |
| h1_o | output | 1 | Horizontal transfer phase 1 |
| h2_o | output | 1 | Horizontal transfer phase 2 |
| rg_o | output | 1 | Reset gate pulse |
| sub_o | output | 1 | Substrate drain pulse |
| sg1_o | output | 1 | Readout pulse into phase-1 gates |
| sg3_o | output | 1 | Readout pulse into phase-3 gates |
| blk_o | output | 1 | Blanking flag |
| pix_ok_o | output | 1 | Effective-pixel qualifier |
| ob_ok_o | output | 1 | Optical-black qualifier |
| even_o | output | 1 | Parity of the current field |

## Verification
The bench builds the block with 4 ticks per pixel and a 22-period line: 12 blanking periods, 2 dummy bits, 1 front OB pixel, 5 effective pixels and 2 rear OB pixels. The frame has 25 lines, giving fields of 13 and 12 lines, with 2 + 4 + 1 output lines. With this configuration every clock of 32 complete fields can be compared against an arithmetic model. The sweep covers both parities, runs of repeated parity, and every shutter value from 0 (drain on all lines after readout) up to values beyond the field length (no drain). Mid-field changes to both inputs show that capture happens only at field start.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  typedef struct packed {
    logic [3:0] v;
    logic       h1;
    logic       h2;
    logic       rg;
    logic       sub;
    logic       sg1;
    logic       sg3;
    logic       blk;
    logic       pix_ok;
    logic       ob_ok;
  } drive_t;

  localparam drive_t DRIVE_IDLE = '{v: 4'b0011, h1: 1'b1, h2: 1'b0, rg: 1'b0,
                                    sub: 1'b0, sg1: 1'b0, sg3: 1'b0, blk: 1'b1,
                                    pix_ok: 1'b0, ob_ok: 1'b0};

  // lines in a field: odd takes the rounded-up half of the frame
  function automatic int field_len(int frame, logic even);
    return even ? frame / 2 : (frame + 1) / 2;
  endfunction

  // vertical phase pattern per transfer state, bit 0 = phase 1
  function automatic logic [3:0] vpat(int st);
    case (st)
      1:       return 4'b0110;
      2:       return 4'b1100;
      3:       return 4'b1001;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic in_win(int x, int lo, int w);
    return (x >= lo) && (x < lo + w);
  endfunction

endpackage

// File: rtl/ccdtg_hcount.sv
module ccdtg_hcount #(
  parameter int PIX_TICKS = 4,
  parameter int LINE_PIX  = 910,
  parameter int TW        = 2,
  parameter int PW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] tick_o,
  output logic [PW-1:0] pix_o,
  output logic          origin_o,
  output logic          line_end_o
);
  localparam logic [TW-1:0] TICK_LAST = TW'(PIX_TICKS - 1);
  localparam logic [PW-1:0] PIX_LAST  = PW'(LINE_PIX - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] pix_q;
  logic          tick_wrap;

  assign tick_wrap  = (tick_q == TICK_LAST);
  assign line_end_o = tick_wrap && (pix_q == PIX_LAST);
  assign origin_o   = (tick_q == '0) && (pix_q == '0);
  assign tick_o     = tick_q;
  assign pix_o      = pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      pix_q  <= '0;
    end else begin
      tick_q <= tick_wrap ? '0 : tick_q + TW'(1);
      if (tick_wrap) pix_q <= line_end_o ? '0 : pix_q + PW'(1);
    end
  end
endmodule

// File: rtl/ccdtg_vcount.sv
module ccdtg_vcount
  import ccdtg_pkg::*;
#(
  parameter int FRAME_LINES = 525,
  parameter int LW          = 9,
  parameter int SHUT_W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              origin_i,
  input  logic              line_end_i,
  input  logic              fld_even_i,
  input  logic [SHUT_W-1:0] shut_i,
  output logic [LW-1:0]     line_o,
  output logic              even_o,
  output logic [SHUT_W-1:0] shut_o,
  output logic              fld_start_o
);
  logic [LW-1:0]     line_q;
  logic              even_q;
  logic [SHUT_W-1:0] shut_q;
  logic              last_line;

  assign fld_start_o = origin_i && (line_q == '0);
  // capture at the very first clock of a field, hold elsewhere
  assign even_o = fld_start_o ? fld_even_i : even_q;
  assign shut_o = fld_start_o ? shut_i : shut_q;
  assign line_o = line_q;

  always_comb begin
    last_line = (int'(line_q) == field_len(FRAME_LINES, even_o) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      even_q <= 1'b0;
      shut_q <= '0;
    end else begin
      even_q <= even_o;
      shut_q <= shut_o;
      if (line_end_i) line_q <= last_line ? '0 : line_q + LW'(1);
    end
  end
endmodule

// File: rtl/ccdtg_decode.sv
module ccdtg_decode
  import ccdtg_pkg::*;
#(
  parameter int PIX_TICKS   = 4,
  parameter int HBLK        = 77,
  parameter int HDUM        = 22,
  parameter int HOBF        = 3,
  parameter int HEFF        = 768,
  parameter int FRAME_LINES = 525,
  parameter int VBLK        = 7,
  parameter int VOBF        = 6,
  parameter int VEFF        = 247,
  parameter int VOBR        = 1,
  parameter int RD_LINE     = 3,
  parameter int RD_P0       = 10,
  parameter int RD_W        = 9,
  parameter int RD_GAP      = 4,
  parameter int VT_P0       = 4,
  parameter int VT_W        = 8,
  parameter int SUB_P0      = 50,
  parameter int SUB_W       = 6,
  parameter int TW          = 2,
  parameter int PW          = 10,
  parameter int LW          = 9,
  parameter int SHUT_W      = 9
) (
  input  logic [TW-1:0]     tick_i,
  input  logic [PW-1:0]     pix_i,
  input  logic [LW-1:0]     line_i,
  input  logic              even_i,
  input  logic [SHUT_W-1:0] shut_i,
  output drive_t            drv_o
);
  localparam int HALF   = PIX_TICKS / 2;
  localparam int VOUT   = VOBF + VEFF + VOBR;
  localparam int RD_P1  = RD_P0 + RD_W + RD_GAP;
  localparam int EFF_LO = HDUM + HOBF;

  always_comb begin
    int t, p, l, s, q, o, fl, vst;
    logic hb, dline, effl, effp, rdl, first, second;
    t  = int'(tick_i);
    p  = int'(pix_i);
    l  = int'(line_i);
    s  = int'(shut_i);
    fl = field_len(FRAME_LINES, even_i);
    hb = (p < HBLK);
    q  = p - HBLK;
    o  = l - VBLK - (even_i ? 1 : 0);
    dline = (o >= 0) && (o < VOUT);
    effl  = dline && in_win(o, VOBF, VEFF);
    effp  = !hb && in_win(q, EFF_LO, HEFF);
    rdl   = (l == RD_LINE);

    vst = 0;
    if (hb && !rdl && in_win(p, VT_P0, 3 * VT_W)) vst = 1 + (p - VT_P0) / VT_W;

    first  = rdl && in_win(p, RD_P0, RD_W);
    second = rdl && in_win(p, RD_P1, RD_W);

    drv_o        = DRIVE_IDLE;
    drv_o.v      = vpat(vst);
    drv_o.h1     = hb ? 1'b1 : (t <= HALF);
    drv_o.h2     = hb ? 1'b0 : ((t >= HALF) || (t == 0));
    drv_o.rg     = !hb && (t == 1);
    drv_o.sg1    = even_i ? second : first;
    drv_o.sg3    = even_i ? first : second;
    drv_o.sub    = hb && in_win(p, SUB_P0, SUB_W) && (l > RD_LINE) && (l + s < fl);
    drv_o.blk    = hb || !dline;
    drv_o.pix_ok = effl && effp;
    drv_o.ob_ok  = dline && !hb && (q >= HDUM) && !(effl && effp);
  end
endmodule

// File: rtl/ccdtg_top.sv
module ccdtg_top
  import ccdtg_pkg::*;
#(
  parameter int PIX_TICKS   = 4,
  parameter int HBLK        = 77,
  parameter int HDUM        = 22,
  parameter int HOBF        = 3,
  parameter int HEFF        = 768,
  parameter int HOBR        = 40,
  parameter int FRAME_LINES = 525,
  parameter int VBLK        = 7,
  parameter int VOBF        = 6,
  parameter int VEFF        = 247,
  parameter int VOBR        = 1,
  parameter int RD_LINE     = 3,
  parameter int RD_P0       = 10,
  parameter int RD_W        = 9,
  parameter int RD_GAP      = 4,
  parameter int VT_P0       = 4,
  parameter int VT_W        = 8,
  parameter int SUB_P0      = 50,
  parameter int SUB_W       = 6,
  parameter int SHUT_W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fld_even_i,
  input  logic [SHUT_W-1:0] shut_i,
  output logic [3:0]        v_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              rg_o,
  output logic              sub_o,
  output logic              sg1_o,
  output logic              sg3_o,
  output logic              blk_o,
  output logic              pix_ok_o,
  output logic              ob_ok_o,
  output logic              even_o
);
  localparam int LINE_PIX = HBLK + HDUM + HOBF + HEFF + HOBR;
  localparam int TW       = $clog2(PIX_TICKS);
  localparam int PW       = $clog2(LINE_PIX);
  localparam int LW       = $clog2((FRAME_LINES + 1) / 2 + 1);

  logic [TW-1:0]     tick;
  logic [PW-1:0]     pix;
  logic [LW-1:0]     line;
  logic              origin, line_end, fld_start, even_cur;
  logic [SHUT_W-1:0] shut_cur;
  drive_t            drv_next, drv_q;
  logic              even_q;

  ccdtg_hcount #(.PIX_TICKS(PIX_TICKS), .LINE_PIX(LINE_PIX), .TW(TW), .PW(PW)) i_hcount (
    .clk(clk), .rst(rst), .tick_o(tick), .pix_o(pix),
    .origin_o(origin), .line_end_o(line_end));

  ccdtg_vcount #(.FRAME_LINES(FRAME_LINES), .LW(LW), .SHUT_W(SHUT_W)) i_vcount (
    .clk(clk), .rst(rst), .origin_i(origin), .line_end_i(line_end),
    .fld_even_i(fld_even_i), .shut_i(shut_i), .line_o(line),
    .even_o(even_cur), .shut_o(shut_cur), .fld_start_o(fld_start));

  ccdtg_decode #(
    .PIX_TICKS(PIX_TICKS), .HBLK(HBLK), .HDUM(HDUM), .HOBF(HOBF), .HEFF(HEFF),
    .FRAME_LINES(FRAME_LINES), .VBLK(VBLK), .VOBF(VOBF), .VEFF(VEFF), .VOBR(VOBR),
    .RD_LINE(RD_LINE), .RD_P0(RD_P0), .RD_W(RD_W), .RD_GAP(RD_GAP),
    .VT_P0(VT_P0), .VT_W(VT_W), .SUB_P0(SUB_P0), .SUB_W(SUB_W),
    .TW(TW), .PW(PW), .LW(LW), .SHUT_W(SHUT_W)
  ) i_decode (
    .tick_i(tick), .pix_i(pix), .line_i(line), .even_i(even_cur),
    .shut_i(shut_cur), .drv_o(drv_next));

  // one register stage on every phase: decode glitches never reach the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= DRIVE_IDLE;
      even_q <= 1'b0;
    end else begin
      drv_q  <= drv_next;
      even_q <= even_cur;
    end
  end

  assign v_o      = drv_q.v;
  assign h1_o     = drv_q.h1;
  assign h2_o     = drv_q.h2;
  assign rg_o     = drv_q.rg;
  assign sub_o    = drv_q.sub;
  assign sg1_o    = drv_q.sg1;
  assign sg3_o    = drv_q.sg3;
  assign blk_o    = drv_q.blk;
  assign pix_ok_o = drv_q.pix_ok;
  assign ob_ok_o  = drv_q.ob_ok;
  assign even_o   = even_q;
endmodule

// File: rtl/ccdtg_checker.sv
module ccdtg_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] v,
  input logic       h1,
  input logic       h2,
  input logic       rg,
  input logic       sub,
  input logic       sg1,
  input logic       sg3,
  input logic       blk,
  input logic       pix_ok,
  input logic       ob_ok,
  input logic       even,
  input logic       fld_start
);
  a_r5_h_overlap_never_both_low: assert property (@(posedge clk) disable iff (rst)
    h1 || h2);

  a_r6_rg_single_clock: assert property (@(posedge clk) disable iff (rst)
    rg |=> !rg);

  a_r6_rg_in_h1_half: assert property (@(posedge clk) disable iff (rst)
    rg |-> (h1 && !h2 && !(blk && !pix_ok && !ob_ok && v != 4'b0011)));

  a_r7_two_phases_high: assert property (@(posedge clk) disable iff (rst)
    ($countones(v) == 2) && (v != 4'b0101) && (v != 4'b1010));

  a_r7_neighbour_step: assert property (@(posedge clk) disable iff (rst)
    (v != $past(v)) |-> ($countones(v ^ $past(v)) == 2));

  a_r7_transfer_in_blank: assert property (@(posedge clk) disable iff (rst)
    (v != 4'b0011) |-> (blk && !rg));

  a_r8_readout_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sg1 && sg3));

  a_r8_readout_blanked: assert property (@(posedge clk) disable iff (rst)
    (sg1 || sg3) |-> (blk && v == 4'b0011));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pix_ok && ob_ok));

  a_r4_flags_unblanked: assert property (@(posedge clk) disable iff (rst)
    (pix_ok || ob_ok) |-> !blk);

  a_r9_drain_in_blank: assert property (@(posedge clk) disable iff (rst)
    sub |-> (blk && !rg && !sg1 && !sg3));

  a_r10_parity_held: assert property (@(posedge clk) disable iff (rst)
    !fld_start |=> $stable(even));
endmodule

bind ccdtg_top ccdtg_checker i_checker (
  .clk(clk), .rst(rst), .v(v_o), .h1(h1_o), .h2(h2_o), .rg(rg_o), .sub(sub_o),
  .sg1(sg1_o), .sg3(sg3_o), .blk(blk_o), .pix_ok(pix_ok_o), .ob_ok(ob_ok_o),
  .even(even_o), .fld_start(fld_start));

// File: tb/test_ccdtg_top.sv
`timescale 1ns/1ps
module test_ccdtg_top;
  localparam int PT = 4, HB = 12, HD = 2, HF = 1, HE = 5, HR = 2;
  localparam int FR = 25, VB = 3, VF = 2, VE = 4, VR = 1;
  localparam int RL = 1, RP = 2, RW = 3, RG = 1, VP = 1, VW = 2, SP = 8, SW = 2;
  localparam int SHW = 4, LP = HB + HD + HF + HE + HR, NF = 32;

  logic clk = 1'b0, rst = 1'b1, fld_even = 1'b0;
  logic [SHW-1:0] shut = '0;
  logic [3:0] v;
  logic h1, h2, rg, sub, sg1, sg3, blk, pv, ov, ev;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ccdtg_top #(
    .PIX_TICKS(PT), .HBLK(HB), .HDUM(HD), .HOBF(HF), .HEFF(HE), .HOBR(HR),
    .FRAME_LINES(FR), .VBLK(VB), .VOBF(VF), .VEFF(VE), .VOBR(VR),
    .RD_LINE(RL), .RD_P0(RP), .RD_W(RW), .RD_GAP(RG), .VT_P0(VP), .VT_W(VW),
    .SUB_P0(SP), .SUB_W(SW), .SHUT_W(SHW)
  ) i_ccdtg_top (
    .clk(clk), .rst(rst), .fld_even_i(fld_even), .shut_i(shut), .v_o(v),
    .h1_o(h1), .h2_o(h2), .rg_o(rg), .sub_o(sub), .sg1_o(sg1), .sg3_o(sg3),
    .blk_o(blk), .pix_ok_o(pv), .ob_ok_o(ov), .even_o(ev));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_of(int n);
    return (n % 3) == 1;
  endfunction

  function automatic logic [SHW-1:0] shut_of(int n);
    return SHW'(n % 16);
  endfunction

  // arithmetic model: {v[3:0],h1,h2,rg,sub,sg1,sg3,blk,pix,ob,even}
  function automatic logic [13:0] model(int t, int p, int l, bit e, int s);
    logic [3:0] vv;
    bit a, b, c, d, s1, s3, bl, px, ob, act;
    int col, row, fl, k;
    fl  = e ? FR / 2 : FR - FR / 2;
    col = p - HB;
    row = l - VB - int'(e);
    act = (row >= 0) && (row < VF + VE + VR);
    if (col < 0) begin a = 1; b = 0; c = 0; end
    else begin a = (t < PT / 2 + 1); b = (t == 0) || (t >= PT / 2); c = (t == 1); end
    vv = 4'b0011;
    k  = p - VP;
    if (col < 0 && l != RL) begin
      if (k >= 0 && k < VW) vv = 4'b0110;
      else if (k >= VW && k < 2 * VW) vv = 4'b1100;
      else if (k >= 2 * VW && k < 3 * VW) vv = 4'b1001;
    end
    s1 = (l == RL) && (p >= RP) && (p < RP + RW);
    s3 = (l == RL) && (p >= RP + RW + RG) && (p < RP + 2 * RW + RG);
    if (e) begin bl = s1; s1 = s3; s3 = bl; end
    d  = (col < 0) && (p >= SP) && (p < SP + SW) && (l >= RL + 1) && (s <= fl - l - 1);
    bl = (col < 0) || !act;
    px = act && (row >= VF) && (row < VF + VE) && (col >= HD + HF) && (col < HD + HF + HE);
    ob = act && (col >= HD) && !px;
    return {vv, a, b, c, d, s1, s3, bl, px, ob, e};
  endfunction

  function automatic string req_of(logic [13:0] diff);
    if (|diff[13:10]) return "R7";
    if (|diff[9:8])   return "R5";
    if (diff[7])      return "R6";
    if (diff[6])      return "R9";
    if (|diff[5:4])   return "R8";
    if (diff[3])      return "R2";
    if (|diff[2:1])   return "R4";
    return "R10";
  endfunction

  initial begin
    logic [13:0] got, want, prev;
    fld_even = par_of(0);
    shut = shut_of(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      got = {v, h1, h2, rg, sub, sg1, sg3, blk, pv, ov, ev};
      check(got === 14'b0011_1000_0010_00, "R1 reset state", int'(got), 14'b0011_1000_0010_00);
    end
    rst = 1'b0;
    prev = {v, h1, h2, rg, sub, sg1, sg3, blk, pv, ov, ev};
    for (int n = 0; n < NF; n++) begin
      bit fe;
      int fs, fl, npix, nrg, nsub, nv, first_ob, at1, at3;
      fe = par_of(n);
      fs = int'(shut_of(n));
      fl = fe ? FR / 2 : FR - FR / 2;
      npix = 0; nrg = 0; nsub = 0; nv = 0; first_ob = -1; at1 = -1; at3 = -1;
      for (int l = 0; l < fl; l++)
        for (int p = 0; p < LP; p++)
          for (int t = 0; t < PT; t++) begin
            @(negedge clk);
            got  = {v, h1, h2, rg, sub, sg1, sg3, blk, pv, ov, ev};
            want = model(t, p, l, fe, fs);
            total++;
            if (got !== want) begin
              bad++;
              $display("FAIL %s field=%0d line=%0d pix=%0d tick=%0d actual=%h expected=%h",
                       req_of(got ^ want), n, l, p, t, got, want);
            end
            if (pv) npix++;
            if (rg && !prev[7]) nrg++;
            if (sub && !prev[6]) nsub++;
            if (v != prev[13:10]) nv++;
            if (ov && first_ob < 0) first_ob = l;
            if (sg1 && !prev[5] && at1 < 0) at1 = p;
            if (sg3 && !prev[4] && at3 < 0) at3 = p;
            prev = got;
            if (l == 4 && p == 0 && t == 0) begin
              fld_even = !fe;
              shut = ~shut_of(n);
            end
            if (l == fl - 1 && p == LP - 1 && t == PT - 1) begin
              fld_even = par_of(n + 1);
              shut = shut_of(n + 1);
            end
          end
      check(npix == VE * HE * PT, "R4 effective clocks per field", npix, VE * HE * PT);
      check(nrg == fl * (LP - HB), "R6 reset gate pulses per field", nrg, fl * (LP - HB));
      check(nsub == ((fl - fs - RL - 1) > 0 ? fl - fs - RL - 1 : 0),
            "R9 drain lines per field", nsub, (fl - fs - RL - 1) > 0 ? fl - fs - RL - 1 : 0);
      check(nv == 4 * (fl - 1), "R7 phase changes per field", nv, 4 * (fl - 1));
      check(first_ob == VB + int'(fe), "R3 first output line", first_ob, VB + int'(fe));
      check(fe ? (at3 == RP && at1 > at3) : (at1 == RP && at3 > at1),
            "R8 readout order", fe ? at3 : at1, RP);
      check(ev == fe, "R10 captured parity", int'(ev), int'(fe));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule